// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources into one flag register and one enable register. Five sources are single-cycle event pulses from internal logic, such as a timer. Two sources come from external control lines, CA1 and CA2. Each control line passes through a synchroniser and then an edge detector whose polarity is set by a control register. A CPU reaches the block through a byte-wide register port. Through that port it can clear flags, set or clear individual enable bits, and read back a summary bit that shows whether any enabled flag is pending. The active-high `irq` output is raised whenever an enabled flag is set.

The enable register takes set/clear writes: bit 7 of the written byte chooses whether the other ones in the byte set their enable bits or clear them. The parameter `GATED_CLEAR` chooses how a flag write behaves. With `GATED_CLEAR` = 0, writing a one to a flag bit clears that flag. With `GATED_CLEAR` = 1, a flag write clears anything only when bit 7 of the written byte is also one.

The register map is selected by `bus_addr`:
- 0 is the port data location. Any access there clears the control-line flags. A read there returns zero.
- 1 is the control register.
- 2 is the flag register.
- 3 is the enable register.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags, enables and the control register are zero and `irq` is low. A read of the flag register returns 0x00, the enable register 0x80 and the control register 0x00.
- R2: A write to the enable register with bit 7 = 1 sets each enable bit written as 1. Enable bits written as 0 keep their value.
- R3: A write to the enable register with bit 7 = 0 clears each enable bit written as 1. Enable bits written as 0 keep their value, so writing 0x7F disables every source.
- R4: With `GATED_CLEAR` = 0, a write to the flag register clears each flag written as 1, whatever the value of bit 7. Writing 0x7F clears every flag.
- R5: With `GATED_CLEAR` = 1, a flag write clears the flags written as 1 only when bit 7 of the written byte is 1. Otherwise it changes no flag.
- R6: `irq` is high exactly when some bit in 6..0 has both its flag and its enable set. Bit 7 of a flag register read returns the same value.
- R7: A pulse on `ext_evt[k]` sets flag bit k+2. The timer pulse is `ext_evt[4]` and it sets flag 6.
- R8: Flag 1 is set by an edge on `ca1_pin`. Control bit 0 selects the edge: 0 selects falling and 1 selects rising. An edge of the other polarity leaves the flag unchanged.
- R9: Control bits 3..1 configure CA2, which sets flag 0. The codes are:
  - 000: falling edge, cleared on port access.
  - 001: falling edge, independent.
  - 010: rising edge, cleared on port access.
  - 011: rising edge, independent.
  - 1xx: CA2 never sets the flag.
- R10: A read or write at the port data location clears flag 1. It also clears flag 0, unless control bits 3..1 are 0x1, the independent modes, in which case flag 0 is kept.
- R11: If a flag is set by its source in the same cycle that a write clears it, the flag ends up set.
- R12: The control register reads back the full byte last written, including bits 7..4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (0 port, 1 control, 2 flags, 3 enables) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ext_evt | input | 5 | Event pulses for flags 6..2 |
| ca1_pin | input | 1 | Control line CA1, asynchronous |
| ca2_pin | input | 1 | Control line CA2, asynchronous |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check the register-update rules on every cycle:
- the set/clear arithmetic of the enable register;
- that a source set overrides a clear in the same cycle;
- that a cleared flag really drops;
- that flags hold when nothing touches them;
- that a gated-mode write without bit 7 removes no flag;
- that an independent-mode port access keeps the CA2 flag;
- that no request is raised while all enables are zero.

Edge polarity selection for CA1 and CA2, the ignored output modes, the read-back encodings and the agreement between the two clear conventions can only be shown by the bench's scenarios. The bench drives two instances, one per convention, with the same stimulus and compares both against its own model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int NFLAG   = 7;
  localparam int EXT_W   = NFLAG - 2;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int NLINE   = 2;
  localparam int LINE_C1 = 0;
  localparam int LINE_C2 = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_FLAGS = 2'd2,
    REG_ENA   = 2'd3
  } reg_sel_e;

  // set/clear update selected by the top bit of the written byte
  function automatic logic [NFLAG-1:0] ena_apply(input logic [NFLAG-1:0] cur,
                                                 input logic [DATA_W-1:0] wd);
    return wd[DATA_W-1] ? (cur | wd[NFLAG-1:0]) : (cur & ~wd[NFLAG-1:0]);
  endfunction

  // bits removed from the flag register by a flag write
  function automatic logic [NFLAG-1:0] flag_wipe(input logic [DATA_W-1:0] wd,
                                                 input logic gated);
    return (gated && !wd[DATA_W-1]) ? '0 : wd[NFLAG-1:0];
  endfunction

  function automatic logic any_live(input logic [NFLAG-1:0] f,
                                    input logic [NFLAG-1:0] e);
    return |(f & e);
  endfunction

  // control byte decode for the two control lines
  function automatic logic c1_rising(input logic [DATA_W-1:0] c);
    return c[0];
  endfunction

  function automatic logic c2_armed(input logic [DATA_W-1:0] c);
    return !c[3];
  endfunction

  function automatic logic c2_rising(input logic [DATA_W-1:0] c);
    return c[2];
  endfunction

  function automatic logic c2_indep(input logic [DATA_W-1:0] c);
    return !c[3] && c[1];
  endfunction

endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic arm,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= pin;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur    = sync_q[SYNC_STAGES-1];
  assign edge_o = arm && (rise_sel ? (cur && !prev_q) : (!cur && prev_q));

  // a rising detection cannot repeat on the very next cycle
  AST_RISE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && rise_sel) |=> !(edge_o && rise_sel)); // R8

  AST_FALL_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && !rise_sel) |=> !(edge_o && !rise_sel)); // R8

endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  output logic [NFLAG-1:0] flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec))); // R11

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0)); // R4

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(flags_q)); // R4

endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [NFLAG-1:0]  en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_stb) en_q <= ena_apply(en_q, wdata);
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata[DATA_W-1]) |=> ((en_q & $past(wdata[NFLAG-1:0])) == $past(wdata[NFLAG-1:0]))); // R2

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wdata[DATA_W-1]) |=> ((en_q & $past(wdata[NFLAG-1:0])) == '0)); // R3

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ((en_q & ~$past(wdata[NFLAG-1:0])) == ($past(en_q) & ~$past(wdata[NFLAG-1:0])))); // R2

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit GATED_CLEAR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EXT_W-1:0]  ext_evt,
  input  logic              ca1_pin,
  input  logic              ca2_pin,
  output logic              irq
);

  logic [DATA_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  flags_q;
  logic [NFLAG-1:0]  en_q;
  logic [NFLAG-1:0]  set_vec;
  logic [NFLAG-1:0]  clr_vec;
  logic [NFLAG-1:0]  port_clr;
  logic              ctrl_wr;
  logic              flag_wr;
  logic              ena_wr;
  logic              port_stb;
  logic              pending;
  logic [NLINE-1:0]  line_pin;
  logic [NLINE-1:0]  line_rise;
  logic [NLINE-1:0]  line_arm;
  logic [NLINE-1:0]  line_edge;

  // access decode
  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == REG_CTRL);
  assign flag_wr  = bus_sel && bus_wr && (bus_addr == REG_FLAGS);
  assign ena_wr   = bus_sel && bus_wr && (bus_addr == REG_ENA);
  assign port_stb = bus_sel && (bus_addr == REG_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata;
  end

  // control line edge detectors
  assign line_pin[LINE_C1]  = ca1_pin;
  assign line_rise[LINE_C1] = c1_rising(ctrl_q);
  assign line_arm[LINE_C1]  = 1'b1;
  assign line_pin[LINE_C2]  = ca2_pin;
  assign line_rise[LINE_C2] = c2_rising(ctrl_q);
  assign line_arm[LINE_C2]  = c2_armed(ctrl_q);

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    irqc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (line_pin[g]),
      .rise_sel (line_rise[g]),
      .arm      (line_arm[g]),
      .edge_o   (line_edge[g])
    );
  end

  // flag sources: internal events on 6..2, CA1 on 1, CA2 on 0
  assign set_vec = {ext_evt, line_edge[LINE_C1], line_edge[LINE_C2]};

  assign port_clr = port_stb ? {{(NFLAG-2){1'b0}}, 1'b1, !c2_indep(ctrl_q)} : '0;
  assign clr_vec  = (flag_wr ? flag_wipe(bus_wdata, GATED_CLEAR) : '0) | port_clr;

  irqc_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q)
  );

  irqc_enable_bank u_enables (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (ena_wr),
    .wdata  (bus_wdata),
    .en_q   (en_q)
  );

  assign pending = any_live(flags_q, en_q);
  assign irq     = pending;

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      REG_CTRL:  bus_rdata = ctrl_q;
      REG_FLAGS: bus_rdata = {pending, flags_q};
      REG_ENA:   bus_rdata = {1'b1, en_q};
      default:   bus_rdata = '0;
    endcase
  end

  AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R6

  AST_INDEP_KEEPS_CA2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_stb && c2_indep(ctrl_q) && flags_q[0]) |=> flags_q[0]); // R10

  AST_PORT_DROPS_CA1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_stb && !line_edge[LINE_C1]) |=> !flags_q[1]); // R10

  if (GATED_CLEAR) begin : g_gated_chk
    AST_GATED_NO_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && !bus_wdata[DATA_W-1]) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5
  end

endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [4:0] ext_evt = 5'd0;
  logic       ca1_pin = 1'b0;
  logic       ca2_pin = 1'b0;
  logic [7:0] rdata_a, rdata_b;
  logic       irq_a, irq_b;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [6:0] mf_a = '0, mf_b = '0, men = '0;
  logic [7:0] mctrl = '0;
  logic [7:0] rd_a, rd_b;

  always #5 clk = ~clk;

  irq_flag_ctrl #(.SYNC_STAGES(2), .GATED_CLEAR(1'b0)) u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .ext_evt(ext_evt), .ca1_pin(ca1_pin), .ca2_pin(ca2_pin), .irq(irq_a));

  irq_flag_ctrl #(.SYNC_STAGES(2), .GATED_CLEAR(1'b1)) u_irq_flag_ctrl_gated (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .ext_evt(ext_evt), .ca1_pin(ca1_pin), .ca2_pin(ca2_pin), .irq(irq_b));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%02h expected=0x%02h", tag, got, exp);
    end
  endtask

  function automatic logic [6:0] bench_ena(input logic [6:0] cur, input logic [7:0] d);
    logic [6:0] r = cur;
    for (int i = 0; i < 7; i++)
      if (d[i]) r[i] = d[7];
    return r;
  endfunction

  function automatic logic bench_live(input logic [6:0] f, input logic [6:0] e);
    logic r = 1'b0;
    for (int i = 0; i < 7; i++) r = r | (f[i] & e[i]);
    return r;
  endfunction

  // one bus cycle, then back to idle; the model follows the requirements
  task automatic cyc(input logic s, input logic w, input logic [1:0] a,
                     input logic [7:0] d, input logic [4:0] e);
    logic [6:0] ca, cb, pc, sv;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; ext_evt = e;
    #2;
    rd_a = rdata_a; rd_b = rdata_b;
    sv = {e, 2'b00};
    ca = '0; cb = '0; pc = '0;
    if (s && w && a == 2'd2) begin
      ca = d[6:0];
      cb = d[7] ? d[6:0] : 7'd0;
    end
    if (s && a == 2'd0) begin
      pc[1] = 1'b1;
      pc[0] = !((mctrl[3:1] == 3'b001) || (mctrl[3:1] == 3'b011));
    end
    mf_a = (mf_a & ~(ca | pc)) | sv;
    mf_b = (mf_b & ~(cb | pc)) | sv;
    if (s && w && a == 2'd3) men = bench_ena(men, d);
    if (s && w && a == 2'd1) mctrl = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd0; ext_evt = 5'd0;
  endtask

  task automatic rd_flags(input string tag);
    logic [7:0] ea, eb;
    ea = {bench_live(mf_a, men), mf_a};
    eb = {bench_live(mf_b, men), mf_b};
    cyc(1'b1, 1'b0, 2'd2, 8'd0, 5'd0);
    chk({tag, " flags"}, rd_a, ea);
    chk({tag, " flags gated"}, rd_b, eb);
  endtask

  task automatic rd_ena(input string tag);
    cyc(1'b1, 1'b0, 2'd3, 8'd0, 5'd0);
    chk({tag, " enables"}, rd_a, {1'b1, men});
  endtask

  task automatic chk_irq(input string tag);
    #1;
    chk({tag, " irq"}, {7'd0, irq_a}, {7'd0, bench_live(mf_a, men)});
    chk({tag, " irq gated"}, {7'd0, irq_b}, {7'd0, bench_live(mf_b, men)});
  endtask

  // change a control line and let it pass the synchroniser and detector
  task automatic line(input int which, input logic v);
    @(negedge clk);
    if (which == 1) ca1_pin = v; else ca2_pin = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic wipe();
    cyc(1'b1, 1'b1, 2'd2, 8'hFF, 5'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd_flags("R1");
    rd_ena("R1");
    cyc(1'b1, 1'b0, 2'd1, 8'd0, 5'd0);
    chk("R1 ctrl", rd_a, 8'h00);
    chk_irq("R1");

    // R2 / R3 enable set and clear
    cyc(1'b1, 1'b1, 2'd3, 8'h83, 5'd0); rd_ena("R2 set");
    cyc(1'b1, 1'b1, 2'd3, 8'hC0, 5'd0); rd_ena("R2 keep");
    cyc(1'b1, 1'b1, 2'd3, 8'h01, 5'd0); rd_ena("R3 clear");
    cyc(1'b1, 1'b1, 2'd3, 8'h7F, 5'd0); rd_ena("R3 all");

    // R7 timer event, R6 summary
    cyc(1'b0, 1'b0, 2'd0, 8'd0, 5'b10000);
    rd_flags("R7 timer");
    chk_irq("R6 masked");
    cyc(1'b1, 1'b1, 2'd3, 8'hC0, 5'd0);
    chk_irq("R6 enabled");
    rd_flags("R6 summary");

    // R4 plain clear vs R5 gated clear
    cyc(1'b1, 1'b1, 2'd2, 8'h40, 5'd0);
    rd_flags("R4 R5 no bit7");
    cyc(1'b1, 1'b1, 2'd2, 8'hC0, 5'd0);
    rd_flags("R5 bit7");

    // R11 set beats clear
    cyc(1'b1, 1'b1, 2'd2, 8'hFF, 5'b00001);
    rd_flags("R11");
    wipe();
    cyc(1'b1, 1'b1, 2'd3, 8'h7F, 5'd0);

    // R8 CA1 falling default
    line(1, 1'b1);
    rd_flags("R8 wrong edge");
    line(1, 1'b0);
    mf_a[1] = 1'b1; mf_b[1] = 1'b1;
    rd_flags("R8 falling");
    cyc(1'b1, 1'b0, 2'd0, 8'd0, 5'd0);
    chk("R10 port read", rd_a, 8'h00);
    rd_flags("R10 port clears CA1");
    cyc(1'b1, 1'b1, 2'd1, 8'h01, 5'd0);
    cyc(1'b1, 1'b0, 2'd1, 8'd0, 5'd0);
    chk("R12 ctrl", rd_a, 8'h01);
    line(1, 1'b1);
    mf_a[1] = 1'b1; mf_b[1] = 1'b1;
    rd_flags("R8 rising");
    wipe();

    // R9 CA2 independent falling
    cyc(1'b1, 1'b1, 2'd1, 8'h02, 5'd0);
    line(2, 1'b1);
    rd_flags("R9 indep fall wrong edge");
    line(2, 1'b0);
    mf_a[0] = 1'b1; mf_b[0] = 1'b1;
    line(1, 1'b0);
    mf_a[1] = 1'b1; mf_b[1] = 1'b1;
    rd_flags("R9 indep fall");
    cyc(1'b1, 1'b1, 2'd0, 8'h00, 5'd0);
    rd_flags("R10 indep keeps CA2");
    wipe();

    // R9 / R12 independent rising via 0x66
    cyc(1'b1, 1'b1, 2'd1, 8'h66, 5'd0);
    cyc(1'b1, 1'b0, 2'd1, 8'd0, 5'd0);
    chk("R12 ctrl 0x66", rd_a, 8'h66);
    line(2, 1'b1);
    mf_a[0] = 1'b1; mf_b[0] = 1'b1;
    rd_flags("R9 indep rise");
    wipe();

    // R9 rising with clear on port access
    cyc(1'b1, 1'b1, 2'd1, 8'h04, 5'd0);
    line(2, 1'b0);
    rd_flags("R9 rise wrong edge");
    line(2, 1'b1);
    mf_a[0] = 1'b1; mf_b[0] = 1'b1;
    rd_flags("R9 rise");
    cyc(1'b1, 1'b0, 2'd0, 8'd0, 5'd0);
    rd_flags("R10 port clears CA2");

    // R9 output mode: no flag
    cyc(1'b1, 1'b1, 2'd1, 8'h08, 5'd0);
    line(2, 1'b0);
    line(2, 1'b1);
    rd_flags("R9 output mode");

    // R9 falling independent via 0x22
    cyc(1'b1, 1'b1, 2'd1, 8'h22, 5'd0);
    line(2, 1'b0);
    mf_a[0] = 1'b1; mf_b[0] = 1'b1;
    rd_flags("R9 ctrl 0x22");
    wipe();

    // random mix of enable writes, flag writes, events and reads
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] d;
      logic [4:0] e;
      op = $urandom_range(0, 6);
      d  = 8'($urandom);
      e  = 5'($urandom);
      case (op)
        0: cyc(1'b1, 1'b1, 2'd3, d, 5'd0);
        1: cyc(1'b1, 1'b1, 2'd2, d, 5'd0);
        2: cyc(1'b0, 1'b0, 2'd0, 8'd0, e);
        3: rd_flags("R4 R5 R6 R7 random");
        4: rd_ena("R2 R3 random");
        5: cyc(1'b1, 1'b1, 2'd2, d, e);
        default: cyc(1'b1, 1'b0, 2'd0, 8'd0, e);
      endcase
      chk_irq("R6 random");
    end
    rd_flags("R11 final");

    summary();
    $finish;
  end

endmodule